// File: doc/BRIEF.md
# PCI Bus Reset and Clock Sequencer

This block brings an attached PCI bus out of reset after the host itself has left power-on reset. It runs from a fast system clock. From that clock it makes the PCI bus clock and the active-low PCI bus reset, and it enforces a fixed bring-up order. First the bus reset is held low with the bus clock stopped, for a minimum hold time. Then the bus clock is started at a programmed rate. A second, shorter settling time follows while the clock runs. Only after that is the bus reset released.

Software starts the sequence with a one-cycle start request and reads progress from a busy flag and a done flag. Once the bus is running, a re-assert request pulls the bus back into reset at once and stops its clock. The full sequence then repeats. The PCI reset output is a separate register and is never derived from the block's own system reset. It is driven low from the moment the system reset is applied, and it can never pulse high until the sequence releases it.

Top module: `pcibus_bringup`

## Requirements
- R1: While the system reset is applied and afterwards, until a start request is seen, the PCI reset output is 0, the PCI clock output is 0, and busy and done are both 0.
- R2: Two wait lengths are derived from the system clock frequency parameter, each rounded up: the no-clock hold is N1 = ceil(SYS_CLK_HZ * HOLD_NOCLK_US / 1e6) cycles and the clock-running hold is N2 = ceil(SYS_CLK_HZ * HOLD_CLK_US / 1e6) cycles, each at least 1.
- R3: A start request in idle raises busy on the next edge. For the first N1 busy cycles the PCI reset output stays 0 and the PCI clock output stays 0.
- R4: The bus clock starts after those N1 cycles. With captured divide value D, where a D of 0 acts as 1, the first rising edge of the PCI clock comes D cycles after the N1-cycle hold ends, and every later half period lasts exactly D system clock cycles.
- R5: The sequence spends one clock-start cycle and then N2 further cycles with the clock running and the reset still 0, so busy lasts N1+1+N2 cycles. After that the PCI reset output is 1, done is 1 and busy is 0.
- R6: The 8-bit divide input is captured only in the clock-start cycle. Changing it later leaves the PCI clock half period unchanged.
- R7: A re-assert request while done is 1 drives the PCI reset output to 0 and the PCI clock output to 0 on the next edge. On that edge done drops and busy rises, and the full sequence of R3 to R5 runs again.
- R8: A start request while busy or done is ignored, and so is a re-assert request while busy. The sequence timing and outputs stay as if no request had come.
- R9: When a start request and a re-assert request arrive in the same cycle in the running state, the re-assert is taken and exactly one new sequence runs.
- R10: Busy and done are never 1 together, and the PCI reset output is 1 only while done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| start_i | input | 1 | One-cycle request to begin the bring-up sequence |
| reassert_i | input | 1 | One-cycle request to put the running bus back into reset |
| div_i | input | 8 | Half-period of the PCI clock in system clock cycles (0 acts as 1) |
| pci_clk_o | output | 1 | Divided PCI bus clock |
| pci_rst_n_o | output | 1 | Active-low PCI bus reset |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Bus released and running |

## Verification
The collision of interest is a start request and a re-assert request landing in the same cycle while the bus runs. The bench drives both on one cycle with a new divide value. It then checks that the reset falls and the clock stops on the next edge. The busy burst that follows must show exactly one sequence, of length N1+1+N2, at the new clock rate. A second kind of overlap, a start or re-assert arriving mid-sequence, is judged by showing that the burst length and the clock-quiet prefix stay at their expected values.

// File: rtl/pcibus_pkg.sv
package pcibus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_HOLD_NOCLK = 3'd1,
        ST_CLK_START  = 3'd2,
        ST_HOLD_CLK   = 3'd3,
        ST_RUN        = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       bus_rst_n;
        logic       busy;
        logic       done;
    } seq_regs_t;

    function automatic longint unsigned ceil_cycles(input longint unsigned hz,
                                                    input longint unsigned usec);
        longint unsigned n;
        n = (hz * usec + 64'd999_999) / 64'd1_000_000;
        return (n == 0) ? 64'd1 : n;
    endfunction

endpackage

// File: rtl/pcibus_wait_timer.sv
module pcibus_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] top_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (tick_i && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            top_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (load_i) top_q <= load_val_i;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R2: the count never climbs above the last loaded length
    a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= top_q);

endmodule

// File: rtl/pcibus_clk_div.sv
module pcibus_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             pclk_o
);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] cnt;
        logic             pclk;
    } div_regs_t;

    div_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.div  = (div_i == '0) ? DIV_W'(1) : div_i;
            r_d.cnt  = '0;
            r_d.pclk = 1'b0;
        end else if (!run_i) begin
            r_d.cnt  = '0;
            r_d.pclk = 1'b0;
        end else if (r_q.cnt == r_q.div - DIV_W'(1)) begin
            r_d.cnt  = '0;
            r_d.pclk = ~r_q.pclk;
        end else begin
            r_d.cnt  = r_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pclk_o = r_q.pclk;

    // R4: phase counter stays inside the captured half period
    a_r4_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.div != '0) |-> (r_q.cnt < r_q.div));

    // R7: a stop request silences the clock on the following edge
    a_r7_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> !pclk_o);

endmodule

// File: rtl/pcibus_bringup.sv
module pcibus_bringup
    import pcibus_pkg::*;
#(
    parameter longint unsigned SYS_CLK_HZ    = 50_000_000,
    parameter longint unsigned HOLD_NOCLK_US = 1000,
    parameter longint unsigned HOLD_CLK_US   = 100,
    parameter int              DIV_W         = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             reassert_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             pci_clk_o,
    output logic             pci_rst_n_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam longint unsigned N_NOCLK = ceil_cycles(SYS_CLK_HZ, HOLD_NOCLK_US);
    localparam longint unsigned N_CLK   = ceil_cycles(SYS_CLK_HZ, HOLD_CLK_US);
    localparam longint unsigned N_MAX   = (N_NOCLK > N_CLK) ? N_NOCLK : N_CLK;
    localparam int              CNT_W   = $clog2(N_MAX + 1);
    localparam logic [CNT_W-1:0] LOAD_NOCLK = CNT_W'(N_NOCLK - 1);
    localparam logic [CNT_W-1:0] LOAD_CLK   = CNT_W'(N_CLK - 1);

    seq_regs_t r_d, r_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_tick;
    logic             tmr_expired;
    logic             div_load;
    logic             div_run;

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = LOAD_NOCLK;
        tmr_tick = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st   = ST_HOLD_NOCLK;
                    tmr_load = 1'b1;
                    tmr_val  = LOAD_NOCLK;
                end
            end
            ST_HOLD_NOCLK: begin
                if (tmr_expired) r_d.st = ST_CLK_START;
                else             tmr_tick = 1'b1;
            end
            ST_CLK_START: begin
                r_d.st   = ST_HOLD_CLK;
                tmr_load = 1'b1;
                tmr_val  = LOAD_CLK;
            end
            ST_HOLD_CLK: begin
                if (tmr_expired) r_d.st = ST_RUN;
                else             tmr_tick = 1'b1;
            end
            ST_RUN: begin
                if (reassert_i) begin
                    r_d.st   = ST_HOLD_NOCLK;
                    tmr_load = 1'b1;
                    tmr_val  = LOAD_NOCLK;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        r_d.bus_rst_n = (r_d.st == ST_RUN);
        r_d.done      = (r_d.st == ST_RUN);
        r_d.busy      = (r_d.st == ST_HOLD_NOCLK) || (r_d.st == ST_CLK_START) ||
                        (r_d.st == ST_HOLD_CLK);
        div_load      = (r_d.st == ST_CLK_START);
        div_run       = (r_d.st == ST_HOLD_CLK) || (r_d.st == ST_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st        <= ST_IDLE;
            r_q.bus_rst_n <= 1'b0;
            r_q.busy      <= 1'b0;
            r_q.done      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    pcibus_wait_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .tick_i     (tmr_tick),
        .expired_o  (tmr_expired)
    );

    pcibus_clk_div #(
        .DIV_W (DIV_W)
    ) u_clkdiv (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (div_load),
        .run_i  (div_run),
        .div_i  (div_i),
        .pclk_o (pci_clk_o)
    );

    assign pci_rst_n_o = r_q.bus_rst_n;
    assign busy_o      = r_q.busy;
    assign done_o      = r_q.done;

    // R10: busy and done exclusive
    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R10: bus reset released only while done
    a_r10_release_only_done: assert property (@(posedge clk) disable iff (!rst_n)
        pci_rst_n_o |-> done_o);

    // R3: no bus clock during the first hold
    a_r3_clk_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HOLD_NOCLK) |-> !pci_clk_o);

    // R5: release happens only from the clock-running hold once it has elapsed
    a_r5_release_order: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pci_rst_n_o) |-> ($past(r_q.st) == ST_HOLD_CLK));

    // R7: re-assert in RUN pulls reset and stops the clock next edge
    a_r7_reassert: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && reassert_i) |=> (!pci_rst_n_o && !pci_clk_o && busy_o));

    // R8: start in the first hold does not restart it
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_HOLD_NOCLK) && !tmr_expired && start_i)
        |=> (r_q.st == ST_HOLD_NOCLK));

endmodule

// File: tb/pcibus_bringup_bench.sv
module pcibus_bringup_bench;

    // 50.5 kHz model clock: N1 = ceil(50.5) = 51, N2 = ceil(5.05) = 6 (R2)
    localparam int EXP_N1 = 51;
    localparam int EXP_N2 = 6;

    typedef struct {
        int busy_len;
        int quiet_len;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       reassert_i = 1'b0;
    logic [7:0] div_i = 8'd0;
    logic       pci_clk_o, pci_rst_n_o, busy_o, done_o;

    int n_cmp = 0;
    int n_bad = 0;
    int bursts = 0;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    pcibus_bringup #(
        .SYS_CLK_HZ    (50_500),
        .HOLD_NOCLK_US (1000),
        .HOLD_CLK_US   (100),
        .DIV_W         (8)
    ) u_pcibus_bringup (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .reassert_i  (reassert_i),
        .div_i       (div_i),
        .pci_clk_o   (pci_clk_o),
        .pci_rst_n_o (pci_rst_n_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: measure every busy burst and compare with the queued expectation
    int  cur_len = 0, cur_quiet = 0, cur_rel = 0;
    logic seen_clk = 1'b0, prev_busy = 1'b0;
    always @(negedge clk) begin
        if (busy_o) begin
            cur_len++;
            if (pci_clk_o) seen_clk = 1'b1;
            if (!seen_clk) cur_quiet++;
            if (pci_rst_n_o) cur_rel++;
        end else if (prev_busy) begin
            exp_t e;
            bursts++;
            if (exp_q.size() == 0) begin
                check("R8 unexpected burst", 1, 0);
            end else begin
                e = exp_q.pop_front();
                check("R5 busy length", cur_len, e.busy_len);
                check("R3/R4 clock quiet prefix", cur_quiet, e.quiet_len);
                check("R3 reset low while busy", cur_rel, 0);
            end
            cur_len = 0; cur_quiet = 0; cur_rel = 0; seen_clk = 1'b0;
        end
        prev_busy = busy_o;
    end

    task automatic wait_done();
        for (int i = 0; i < 2000 && !done_o; i++) @(negedge clk);
    endtask

    task automatic half_period(output int n);
        logic v;
        @(negedge clk);
        v = pci_clk_o;
        for (int i = 0; i < 600 && pci_clk_o == v; i++) @(negedge clk);
        v = pci_clk_o;
        n = 0;
        for (int i = 0; i < 600 && pci_clk_o == v; i++) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse(input logic s, input logic r);
        start_i = s; reassert_i = r;
        @(negedge clk);
        start_i = 1'b0; reassert_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100_000) @(negedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        int hp;
        @(negedge clk);
        // R1 reset values
        check("R1 reset pci_rst_n", pci_rst_n_o, 0);
        check("R1 reset pci_clk", pci_clk_o, 0);
        check("R1 reset busy", busy_o, 0);
        check("R1 reset done", done_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check("R1 idle stays busy=0", busy_o, 0);
        check("R1 idle reset low", pci_rst_n_o, 0);

        // first sequence, D = 3
        div_i = 8'd3;
        exp_q.push_back('{EXP_N1 + 1 + EXP_N2, EXP_N1 + 3});
        pulse(1'b1, 1'b0);
        check("R3 busy after start", busy_o, 1);
        repeat (10) @(negedge clk);
        pulse(1'b0, 1'b1); // R8 re-assert while busy ignored
        wait_done();
        check("R5 done", done_o, 1);
        check("R5 reset released", pci_rst_n_o, 1);
        check("R5 busy low", busy_o, 0);
        half_period(hp);
        check("R4 half period D=3", hp, 3);

        // R6 divide input changed in RUN
        div_i = 8'd5;
        half_period(hp);
        check("R6 half period kept", hp, 3);

        // R8 start in RUN ignored
        pulse(1'b1, 1'b0);
        repeat (3) @(negedge clk);
        check("R8 start in RUN done", done_o, 1);
        check("R8 start in RUN reset", pci_rst_n_o, 1);

        // R9 start and re-assert together, new D = 0 acts as 1
        div_i = 8'd0;
        exp_q.push_back('{EXP_N1 + 1 + EXP_N2, EXP_N1 + 1});
        start_i = 1'b1; reassert_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; reassert_i = 1'b0;
        check("R7 reset low after reassert", pci_rst_n_o, 0);
        check("R7 clock stopped", pci_clk_o, 0);
        check("R7 busy", busy_o, 1);
        check("R7 done low", done_o, 0);
        repeat (10) @(negedge clk);
        pulse(1'b1, 1'b0); // R8 start while busy ignored
        wait_done();
        check("R7 rerun done", done_o, 1);
        half_period(hp);
        check("R4 half period D=0", hp, 1);
        check("R9 bursts seen", bursts, 2);
        check("R9 expectations used", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule